// File: doc/BRIEF.md
# Page access permission checker

This block decides whether a memory access that has already been translated may go ahead. It takes the protection flags of the two table levels that map the page: the directory-level entry and the table-level entry. For a large page it takes only the single directory entry. It also takes the current privilege level, the kind of access, a supervisor write-protect control and a no-execute enable. It answers with an allow signal, a fault signal and a two-bit cause code.

The flags of the two levels are merged so that the more restrictive level always wins. A privilege check, a write-protection check and an execute-disable check are then applied to the merged flags. If more than one check fails, a fixed priority picks the cause that is reported. The block has no state: the answer follows the inputs in the same cycle. It is meant to sit after a page walk or a translation cache lookup. The present-bit test and the delivery of the fault are done elsewhere.

Top module: `pgperm_check`

## Requirements
- R1: An access at privilege level 3 to a page whose effective user bit is 0 faults with cause code 1 (privilege). Levels 0 to 2 never get a privilege fault.
- R2: The effective user bit is the AND of the user bits of all levels in use. The effective writable bit is the AND of their writable bits, so a read-only directory entry overrides a writable table entry.
- R3: When `large_page` is 1, only the directory entry (index 0 of each flag vector) is used. The table-entry bits (index 1) have no effect on the result.
- R4: A write at privilege level 3 to a page whose effective writable bit is 0 faults with cause code 2 (read-only).
- R5: A write at privilege levels 0 to 2 to an effectively read-only page faults with cause code 2 when `wp_en` is 1. When `wp_en` is 0 it is allowed.
- R6: With `nx_en` = 1, an instruction fetch from a page where the execute-disable bit is set in any level in use faults with cause code 3 (no-execute).
- R7: With `nx_en` = 0, the execute-disable bits are ignored and a fetch never gets cause code 3.
- R8: When a privilege violation and another violation both apply, cause code 1 is reported.
- R9: `allow` is always the inverse of `fault`. `cause` is 0 exactly when there is no fault.
- R10: Access type encoding: 0 = read, 1 = write, 2 = instruction fetch, 3 = treated as a read. A read only ever faults for privilege.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lvl_wr | input | NUM_LEVELS | Writable bit per level, index 0 = directory entry |
| lvl_user | input | NUM_LEVELS | User-access bit per level |
| lvl_xd | input | NUM_LEVELS | Execute-disable bit per level |
| large_page | input | 1 | Mapping is a large page; only index 0 is used |
| cpl | input | CPL_W | Current privilege level; 3 is user |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| wp_en | input | 1 | Supervisor write-protect control |
| nx_en | input | 1 | Enables the execute-disable bits |
| allow | output | 1 | Access permitted |
| fault | output | 1 | Access denied |
| cause | output | 2 | 0 none, 1 privilege, 2 read-only, 3 no-execute |

## Verification
The assertions assume that every input is a known value whenever they are evaluated, and they skip any evaluation that sees an unknown. They also assume that `cpl` values above 3 are not used, because they check the user rule against the value 3 only. The bench drives every input from a known value at time zero. It sweeps each combination of flags, privilege levels 0 to 3, access types, `wp_en`, `nx_en` and `large_page`, so only legal privilege levels are applied.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

    // Access kinds; value 3 is treated as a read.
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    // Fault cause codes.
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_PRIV   = 2'd1,
        CAUSE_RDONLY = 2'd2,
        CAUSE_NOEXEC = 2'd3
    } cause_t;

    // Flags after merging the levels.
    typedef struct packed {
        logic writable;
        logic user_ok;
        logic exec_off;
    } eff_flags_t;

    // Individual violations before priority.
    typedef struct packed {
        logic priv;
        logic rdonly;
        logic noexec;
    } viol_t;

endpackage

// File: rtl/pgperm_merge.sv
module pgperm_merge
    import pgperm_pkg::*;
#(
    parameter int NUM_LEVELS = 2
) (
    input  logic [NUM_LEVELS-1:0] lvl_wr,
    input  logic [NUM_LEVELS-1:0] lvl_user,
    input  logic [NUM_LEVELS-1:0] lvl_xd,
    input  logic                  large_page,
    output eff_flags_t            eff
);
    logic [NUM_LEVELS-1:0] in_use;

    // The top level is always used; lower levels only for small pages.
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_use
        if (g == 0) begin : g_top
            assign in_use[g] = 1'b1;
        end else begin : g_low
            assign in_use[g] = ~large_page;
        end
    end

    always_comb begin
        eff.writable = &(lvl_wr   | ~in_use);
        eff.user_ok  = &(lvl_user | ~in_use);
        eff.exec_off = |(lvl_xd   &  in_use);
    end
endmodule

// File: rtl/pgperm_rules.sv
module pgperm_rules
    import pgperm_pkg::*;
#(
    parameter int CPL_W    = 2,
    parameter int USER_CPL = 3
) (
    input  eff_flags_t       eff,
    input  logic [CPL_W-1:0] cpl,
    input  logic [1:0]       acc_type,
    input  logic             wp_en,
    input  logic             nx_en,
    output viol_t            viol
);
    localparam logic [CPL_W-1:0] USER_LVL = CPL_W'(USER_CPL);

    logic is_user;
    logic is_write;
    logic is_fetch;

    always_comb begin
        is_user  = (cpl == USER_LVL);
        is_write = (acc_type == ACC_WRITE);
        is_fetch = (acc_type == ACC_FETCH);

        viol.priv   = is_user & ~eff.user_ok;
        viol.rdonly = is_write & ~eff.writable & (is_user | wp_en);
        viol.noexec = is_fetch & nx_en & eff.exec_off;
    end
endmodule

// File: rtl/pgperm_prio.sv
module pgperm_prio
    import pgperm_pkg::*;
(
    input  viol_t  viol,
    output cause_t cause
);
    always_comb begin
        if (viol.priv) begin
            cause = CAUSE_PRIV;
        end else if (viol.rdonly) begin
            cause = CAUSE_RDONLY;
        end else if (viol.noexec) begin
            cause = CAUSE_NOEXEC;
        end else begin
            cause = CAUSE_NONE;
        end
    end
endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
    import pgperm_pkg::*;
#(
    parameter int NUM_LEVELS = 2,
    parameter int CPL_W      = 2,
    parameter int USER_CPL   = 3
) (
    input  logic [NUM_LEVELS-1:0] lvl_wr,
    input  logic [NUM_LEVELS-1:0] lvl_user,
    input  logic [NUM_LEVELS-1:0] lvl_xd,
    input  logic                  large_page,
    input  logic [CPL_W-1:0]      cpl,
    input  logic [1:0]            acc_type,
    input  logic                  wp_en,
    input  logic                  nx_en,
    output logic                  allow,
    output logic                  fault,
    output logic [1:0]            cause
);
    eff_flags_t eff;
    viol_t      viol;
    cause_t     cause_sel;

    pgperm_merge #(.NUM_LEVELS(NUM_LEVELS)) u_merge (
        .lvl_wr     (lvl_wr),
        .lvl_user   (lvl_user),
        .lvl_xd     (lvl_xd),
        .large_page (large_page),
        .eff        (eff)
    );

    pgperm_rules #(.CPL_W(CPL_W), .USER_CPL(USER_CPL)) u_rules (
        .eff      (eff),
        .cpl      (cpl),
        .acc_type (acc_type),
        .wp_en    (wp_en),
        .nx_en    (nx_en),
        .viol     (viol)
    );

    pgperm_prio u_prio (
        .viol  (viol),
        .cause (cause_sel)
    );

    always_comb begin
        cause = cause_sel;
        fault = (cause_sel != CAUSE_NONE);
        allow = ~fault;
    end

    // Checks on the merged result against the ports.
    always_comb begin
        if (!$isunknown({lvl_wr, lvl_user, lvl_xd, large_page, cpl, acc_type, wp_en, nx_en})) begin
            p_allow_excl_r9: assert (allow != fault)
                else $error("allow and fault agree");
            p_priv_first_r8: assert (!((cpl == CPL_W'(USER_CPL)) && !lvl_user[0]) || cause == CAUSE_PRIV)
                else $error("user access to supervisor directory without privilege cause");
            p_nx_off_r7: assert (nx_en || cause != CAUSE_NOEXEC)
                else $error("no-execute cause while disabled");
            p_wp_off_r5: assert (!(!wp_en && (cpl != CPL_W'(USER_CPL)) && acc_type == ACC_WRITE) || allow)
                else $error("supervisor write blocked with write-protect off");
            p_read_ok_r10: assert (!(acc_type == ACC_READ && eff.user_ok) || allow)
                else $error("read of accessible page faulted");
        end
    end
endmodule

// File: tb/pgperm_check_tb.sv
`timescale 1ns/1ps
module pgperm_check_tb;

    typedef struct {
        logic       allow;
        logic [1:0] cause;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0] lvl_wr = '0;
    logic [1:0] lvl_user = '0;
    logic [1:0] lvl_xd = '0;
    logic       large_page = 1'b0;
    logic [1:0] cpl = '0;
    logic [1:0] acc_type = '0;
    logic       wp_en = 1'b0;
    logic       nx_en = 1'b0;
    logic       allow;
    logic       fault;
    logic [1:0] cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    pgperm_check u_dut (
        .lvl_wr(lvl_wr), .lvl_user(lvl_user), .lvl_xd(lvl_xd),
        .large_page(large_page), .cpl(cpl), .acc_type(acc_type),
        .wp_en(wp_en), .nx_en(nx_en),
        .allow(allow), .fault(fault), .cause(cause)
    );

    // Expected result from the requirements.
    function automatic exp_t model(logic [1:0] w, logic [1:0] u, logic [1:0] x, logic lg,
                                   logic [1:0] c, logic [1:0] a, logic wp, logic nx, string tag);
        exp_t e;
        logic ew, eu, ex, usr;
        ew  = lg ? w[0] : (w[0] && w[1]);   // R2, R3
        eu  = lg ? u[0] : (u[0] && u[1]);
        ex  = lg ? x[0] : (x[0] || x[1]);
        usr = (c == 2'd3);
        e.tag = tag;
        if (usr && !eu)                              e.cause = 2'd1; // R1, R8
        else if (a == 2'd1 && !ew && (usr || wp))    e.cause = 2'd2; // R4, R5
        else if (a == 2'd2 && nx && ex)              e.cause = 2'd3; // R6, R7
        else                                         e.cause = 2'd0; // R10
        e.allow = (e.cause == 2'd0);                                 // R9
        return e;
    endfunction

    task automatic drive(logic [1:0] w, logic [1:0] u, logic [1:0] x, logic lg,
                         logic [1:0] c, logic [1:0] a, logic wp, logic nx, string tag);
        @(posedge clk);
        lvl_wr = w; lvl_user = u; lvl_xd = x; large_page = lg;
        cpl = c; acc_type = a; wp_en = wp; nx_en = nx;
        q.push_back(model(w, u, x, lg, c, a, wp, nx, tag));
    endtask

    // Monitor: compare away from the driving edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (allow !== e.allow || fault !== !e.allow || cause !== e.cause) begin
                fails++;
                $display("FAIL %s: allow=%0b fault=%0b cause=%0d expected allow=%0b fault=%0b cause=%0d",
                         e.tag, allow, fault, cause, e.allow, !e.allow, e.cause);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state inputs: all zero, supervisor read.
        drive(2'b00, 2'b00, 2'b00, 0, 2'd0, 2'd0, 0, 0, "R10");
        // R1 user on supervisor table entry
        drive(2'b11, 2'b01, 2'b00, 0, 2'd3, 2'd0, 0, 0, "R1");
        drive(2'b11, 2'b00, 2'b00, 0, 2'd2, 2'd0, 0, 0, "R1");
        // R2 read-only directory overrides writable table
        drive(2'b10, 2'b11, 2'b00, 0, 2'd3, 2'd1, 0, 0, "R2");
        drive(2'b11, 2'b11, 2'b00, 0, 2'd3, 2'd1, 0, 0, "R2");
        // R3 large page ignores table bits
        drive(2'b01, 2'b01, 2'b10, 1, 2'd3, 2'd1, 1, 1, "R3");
        drive(2'b01, 2'b01, 2'b10, 1, 2'd3, 2'd2, 1, 1, "R3");
        // R4 user write read-only
        drive(2'b01, 2'b11, 2'b00, 0, 2'd3, 2'd1, 0, 0, "R4");
        // R5 write-protect on and off
        drive(2'b00, 2'b00, 2'b00, 0, 2'd0, 2'd1, 1, 0, "R5");
        drive(2'b00, 2'b00, 2'b00, 0, 2'd0, 2'd1, 0, 0, "R5");
        // R6 execute-disable at lower level
        drive(2'b11, 2'b11, 2'b10, 0, 2'd3, 2'd2, 0, 1, "R6");
        // R7 execute-disable ignored
        drive(2'b11, 2'b11, 2'b11, 0, 2'd3, 2'd2, 0, 0, "R7");
        // R8 privilege beats read-only
        drive(2'b00, 2'b00, 2'b00, 0, 2'd3, 2'd1, 1, 0, "R8");
        // R10 type 3 acts as read
        drive(2'b00, 2'b11, 2'b11, 0, 2'd3, 2'd3, 1, 1, "R10");
        // Full sweep, R9 on every point
        for (int i = 0; i < 8192; i++) begin
            drive(i[1:0], i[3:2], i[5:4], i[6], i[8:7], i[10:9], i[11], i[12], "R9");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: done=0 expected done=1");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule